// File: doc/BRIEF.md
# UART Receive and Transmit FIFO with Receive Interrupt Control

This block holds the two 16-byte queues of a 16550-class UART and the write-only control byte that governs them. The receive shift register pushes each arriving byte with three error flags, and the CPU pops it. The CPU loads transmit bytes, and the transmit shifter pulls them. From the receive queue the block derives the data-ready status bit, a receive interrupt request with a priority-ordered identification code, and the two DMA request levels, receive-ready and transmit-ready.

While queueing is disabled the block behaves as a single holding register, with a capacity of one and an effective trigger level of one. Once queueing is enabled, the receive interrupt fires at a programmable fill level. A character timeout fires when the receive queue holds data that has gone untouched for four frame times. A frame time is sixteen baud ticks per frame bit, and the frame length in bits, counting both stop bits, is an input.

Top module: `uart_fifo_irq`

## Requirements
- R1: Control bit 0 enables queueing. Any write that changes bit 0, in either direction, empties both queues on that clock edge. While bit 0 is clear, each queue holds at most one byte.
- R2: A control write with bit 0 set and bit 1 set empties the receive queue, and one with bit 0 set and bit 2 set empties the transmit queue. Each flush leaves the other queue untouched. A flush in the same cycle as a push discards the push.
- R3: The receive queue is first-in first-out, and `rx_count` tracks its fill. A push finding the queue at capacity is dropped, even if a read comes in the same cycle, and it sets `overrun`. `overrun` clears on the next read strobe or on a receive flush.
- R4: A CPU read of a non-empty receive queue loads the head byte and its flags into `rx_data`/`rx_data_flags` for the next cycle. A read of an empty queue leaves `rx_data` and the count unchanged.
- R5: Control bits 7:6 pick the receive trigger level when bit 0 is set: 00 selects 1, 01 selects 4, 10 selects 8, 11 selects 14. `irq_id` is 0x4 while `rx_count` is at or above the level and no line-status condition exists, and leaves 0x4 once the count drops below the level.
- R6: A line-status condition is either a set `overrun` or nonzero flags on the head byte. It gives `irq_id` 0x6, which outranks 0x4 and 0xC.
- R7: In queue mode, with at least one byte held, 64 × `frame_bits` baud ticks without a push, a read or a flush raise the timeout, and `irq_id` becomes 0xC unless 0x6 or 0x4 is pending. Any push, read or flush clears the timeout and restarts its count.
- R8: `data_ready` is 1 exactly when the receive queue is non-empty, and it rises only in the cycle after a push.
- R9: Control bit 3 (with bit 0 set) selects mode 1. In mode 0, `rxrdy_n` is low while the receive queue is non-empty, and `txrdy_n` is low while the transmit queue is empty. In mode 1, `rxrdy_n` is low while the count is at or above the trigger level or a timeout is pending, and `txrdy_n` is low while the transmit queue is not full.
- R10: With no interrupt pending, or with `rx_ie` low, `irq` is 0 and `irq_id` is 0x1. Otherwise `irq` is 1.
- R11: The transmit queue is first-in first-out. `tx_head` shows the oldest byte, `tx_pull` removes it, and a write to a full queue or a pull from an empty one changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | CPU write strobe for the control byte |
| ctl_wdata | input | 8 | Control byte value |
| rx_push | input | 1 | Receive shifter delivers a byte |
| rx_byte | input | 8 | Received byte |
| rx_flags | input | 3 | Error flags of the received byte |
| rx_read | input | 1 | CPU read strobe for the receive queue |
| rx_data | output | 8 | Last byte read by the CPU |
| rx_data_flags | output | 3 | Flags of the last byte read |
| rx_count | output | 5 | Receive queue fill |
| tx_write | input | 1 | CPU writes a transmit byte |
| tx_byte | input | 8 | Transmit byte |
| tx_pull | input | 1 | Transmit shifter takes the head byte |
| tx_head | output | 8 | Oldest transmit byte |
| tx_count | output | 5 | Transmit queue fill |
| baud_tick | input | 1 | One pulse per sixteenth of a bit time |
| frame_bits | input | 4 | Bits per frame, start and all stop bits included |
| rx_ie | input | 1 | Receive interrupt enable |
| data_ready | output | 1 | Receive data available status bit |
| overrun | output | 1 | A receive byte was dropped |
| irq | output | 1 | Receive interrupt request |
| irq_id | output | 4 | Interrupt identification code |
| rxrdy_n | output | 1 | Receive DMA request, active low |
| txrdy_n | output | 1 | Transmit DMA request, active low |

## Verification
Two collisions get targeted stimulus. In the first, a control write that flushes the receive queue lands in the same cycle as a shifter push; the bench expects an empty queue afterwards. In the second, a push meets a CPU read on a full queue; the bench expects count 15, `overrun` set, and the read byte in `rx_data`. A reference model in the bench applies the same same-cycle rules to every random cycle, in which pushes, reads, pulls, baud ticks and occasional control writes overlap freely, and each output is compared against that model after every edge.

// File: rtl/ufi_pkg.sv
// Shared constants for the UART queue and interrupt block.
// Assumes: identification codes are four bits wide, bit 0 set means idle.
package ufi_pkg;
    localparam logic [3:0] ID_NONE = 4'h1;
    localparam logic [3:0] ID_LINE = 4'h6;
    localparam logic [3:0] ID_RDA  = 4'h4;
    localparam logic [3:0] ID_TOUT = 4'hC;

    // Map the two trigger-select bits to a fill level.
    function automatic int trig_level(input logic [1:0] sel);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction
endpackage

// File: rtl/ufi_fifo.sv
// Synchronous first-in first-out queue with a run-time capacity limit.
// Assumes: DEPTH is a power of two; cap never exceeds DEPTH; flush has
// priority over push and pop; a push is accepted only when count < cap
// before the edge, whether or not a pop comes in the same cycle.
module ufi_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [CW-1:0] cap,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          dropped
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] rd_ptr;
    logic [AW-1:0] wr_ptr;
    logic          push_ok;
    logic          pop_ok;

    assign push_ok = push && !flush && (count < cap);
    assign pop_ok  = pop && !flush && (count != '0);
    assign dropped = push && !flush && !(count < cap);
    assign head    = mem[rd_ptr];

    // Pointer and fill bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end

    // Storage write; no reset needed on data.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    assert_fill_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= cap);
    assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush && count == cap) |=> count <= $past(count));
    assert_flush_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> count == '0);
endmodule

// File: rtl/ufi_tout.sv
// Character timeout timer counting baud ticks up to 64 x frame length.
// Assumes: restart pulses on any push, read or flush; active is high only
// in queue mode with a non-empty receive queue.
module ufi_tout #(
    parameter int FW  = 4,
    localparam int LW = FW + 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          active,
    input  logic          tick,
    input  logic [FW-1:0] frame_bits,
    output logic          expired
);
    logic [LW-1:0] cnt;
    logic [LW-1:0] limit;

    assign limit = {frame_bits, 6'd0};

    // Count ticks of inactivity and flag expiry once the limit is hit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !active) begin
            cnt     <= '0;
            expired <= 1'b0;
        end else if (tick && !expired) begin
            if (cnt == limit - 1'b1) expired <= 1'b1;
            else                     cnt     <= cnt + 1'b1;
        end
    end

    assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !expired);
    assert_expire_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> $past(tick));
endmodule

// File: rtl/uart_fifo_irq.sv
// UART receive/transmit queues, control byte and receive interrupt logic.
// Assumes: control byte is write-only; bits 1 and 2 act once per write;
// bits 4 and 5 are ignored; rx_flags nonzero marks a line error.
module uart_fifo_irq import ufi_pkg::*; #(
    parameter int DEPTH   = 16,
    parameter int DW      = 8,
    parameter int FLAG_W  = 3,
    parameter int FRAME_W = 4,
    localparam int CW     = $clog2(DEPTH + 1),
    localparam int EW     = DW + FLAG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_wr,
    input  logic [7:0]         ctl_wdata,
    input  logic               rx_push,
    input  logic [DW-1:0]      rx_byte,
    input  logic [FLAG_W-1:0]  rx_flags,
    input  logic               rx_read,
    output logic [DW-1:0]      rx_data,
    output logic [FLAG_W-1:0]  rx_data_flags,
    output logic [CW-1:0]      rx_count,
    input  logic               tx_write,
    input  logic [DW-1:0]      tx_byte,
    input  logic               tx_pull,
    output logic [DW-1:0]      tx_head,
    output logic [CW-1:0]      tx_count,
    input  logic               baud_tick,
    input  logic [FRAME_W-1:0] frame_bits,
    input  logic               rx_ie,
    output logic               data_ready,
    output logic               overrun,
    output logic               irq,
    output logic [3:0]         irq_id,
    output logic               rxrdy_n,
    output logic               txrdy_n
);
    logic          en_q;
    logic          mode_q;
    logic [1:0]    trig_sel_q;
    logic          en_chg;
    logic          rx_flush;
    logic          tx_flush;
    logic [CW-1:0] cap;
    logic [CW-1:0] trig_cnt;
    logic [EW-1:0] rx_head;
    logic [EW-1:0] rx_data_q;
    logic          rx_drop;
    logic          tx_dropped_unused;
    logic          ctl_unused;
    logic          rd_take;
    logic          tout;
    logic          mode1;
    logic          line_pend;
    logic          rda_pend;
    logic          tout_pend;
    logic          at_trig;

    assign ctl_unused = ^ctl_wdata[5:4];
    assign en_chg   = ctl_wr && (ctl_wdata[0] != en_q);
    assign rx_flush = en_chg || (ctl_wr && ctl_wdata[0] && ctl_wdata[1]);
    assign tx_flush = en_chg || (ctl_wr && ctl_wdata[0] && ctl_wdata[2]);
    assign cap      = en_q ? CW'(DEPTH) : CW'(1);
    assign trig_cnt = en_q ? CW'(trig_level(trig_sel_q)) : CW'(1);
    assign mode1    = en_q && mode_q;
    assign rd_take  = rx_read && (rx_count != '0);

    // Control byte: enable always latched, other fields only with bit 0 set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q       <= 1'b0;
            mode_q     <= 1'b0;
            trig_sel_q <= 2'b00;
        end else if (ctl_wr) begin
            en_q <= ctl_wdata[0];
            if (ctl_wdata[0]) begin
                mode_q     <= ctl_wdata[3];
                trig_sel_q <= ctl_wdata[7:6];
            end
        end
    end

    ufi_fifo #(.DW(EW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush), .cap(cap),
        .push(rx_push), .wdata({rx_flags, rx_byte}), .pop(rx_read),
        .head(rx_head), .count(rx_count), .dropped(rx_drop)
    );

    ufi_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush), .cap(cap),
        .push(tx_write), .wdata(tx_byte), .pop(tx_pull),
        .head(tx_head), .count(tx_count), .dropped(tx_dropped_unused)
    );

    ufi_tout #(.FW(FRAME_W)) u_tout (
        .clk(clk), .rst_n(rst_n),
        .restart(rx_push || rx_read || rx_flush),
        .active(en_q && (rx_count != '0)),
        .tick(baud_tick), .frame_bits(frame_bits), .expired(tout)
    );

    // Capture the head entry on each read that finds data.
    always_ff @(posedge clk) begin
        if (!rst_n)       rx_data_q <= '0;
        else if (rd_take) rx_data_q <= rx_head;
    end

    // Sticky overrun: set by a dropped push, cleared by a read or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || rx_flush) overrun <= 1'b0;
        else if (rx_drop)       overrun <= 1'b1;
        else if (rx_read)       overrun <= 1'b0;
    end

    assign rx_data       = rx_data_q[DW-1:0];
    assign rx_data_flags = rx_data_q[EW-1:DW];
    assign data_ready    = (rx_count != '0);
    assign at_trig       = (rx_count >= trig_cnt);
    assign line_pend = rx_ie && (overrun || (data_ready && rx_head[EW-1:DW] != '0));
    assign rda_pend  = rx_ie && at_trig;
    assign tout_pend = rx_ie && tout;

    // Priority encoder for the identification code.
    always_comb begin
        if (line_pend)      irq_id = ID_LINE;
        else if (rda_pend)  irq_id = ID_RDA;
        else if (tout_pend) irq_id = ID_TOUT;
        else                irq_id = ID_NONE;
    end

    assign irq     = (irq_id != ID_NONE);
    assign rxrdy_n = mode1 ? !(at_trig || tout) : !data_ready;
    assign txrdy_n = mode1 ? (tx_count == cap) : (tx_count != '0);

    assert_read_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_read && rx_count == '0) |=> $stable(rx_data));
    assert_line_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ie && overrun) |-> irq_id == ID_LINE);
    assert_ready_after_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_ready) |-> $past(rx_push));
    assert_single_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (rx_count <= CW'(1) && tx_count <= CW'(1)));
    assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ie |-> !irq);
endmodule

// File: tb/uart_fifo_irq_bench.sv
// Self-checking bench: directed corners, then seeded random traffic
// against a queue-based reference model.
module uart_fifo_irq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       rx_push = 1'b0;
    logic [7:0] rx_byte = '0;
    logic [2:0] rx_flags = '0;
    logic       rx_read = 1'b0;
    logic [7:0] rx_data;
    logic [2:0] rx_data_flags;
    logic [4:0] rx_count;
    logic       tx_write = 1'b0;
    logic [7:0] tx_byte = '0;
    logic       tx_pull = 1'b0;
    logic [7:0] tx_head;
    logic [4:0] tx_count;
    logic       baud_tick = 1'b0;
    logic [3:0] frame_bits = 4'd7;
    logic       rx_ie = 1'b1;
    logic       data_ready, overrun, irq, rxrdy_n, txrdy_n;
    logic [3:0] irq_id;

    always #10 clk = ~clk;

    uart_fifo_irq u_uart_fifo_irq (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .rx_push(rx_push), .rx_byte(rx_byte), .rx_flags(rx_flags),
        .rx_read(rx_read), .rx_data(rx_data), .rx_data_flags(rx_data_flags),
        .rx_count(rx_count), .tx_write(tx_write), .tx_byte(tx_byte),
        .tx_pull(tx_pull), .tx_head(tx_head), .tx_count(tx_count),
        .baud_tick(baud_tick), .frame_bits(frame_bits), .rx_ie(rx_ie),
        .data_ready(data_ready), .overrun(overrun), .irq(irq),
        .irq_id(irq_id), .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n)
    );

    logic [10:0] rxq[$];
    logic [7:0]  txq[$];
    bit          m_en, m_mode, m_ovr, m_tout;
    logic [1:0]  m_sel;
    int          m_tcnt;
    logic [10:0] m_rdata;
    int          n_chk, n_err;
    bit          done;

    function automatic int f_cap(bit en);
        return en ? 16 : 1;
    endfunction

    function automatic int f_trig();
        if (!m_en) return 1;
        case (m_sel)
            2'b00: return 1;
            2'b01: return 4;
            2'b10: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic logic [3:0] f_id();
        bit ls;
        ls = rx_ie && (m_ovr || (rxq.size() > 0 && rxq[0][10:8] != 3'b000));
        if (ls) return 4'h6;
        if (rx_ie && rxq.size() >= f_trig()) return 4'h4;
        if (rx_ie && m_tout) return 4'hC;
        return 4'h1;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit m1;
        m1 = m_en && m_mode;
        chk("R3 rx_count", 32'(rx_count), 32'(rxq.size()));
        chk("R11 tx_count", 32'(tx_count), 32'(txq.size()));
        chk("R8 data_ready", 32'(data_ready), 32'(rxq.size() != 0));
        chk("R3 overrun", 32'(overrun), 32'(m_ovr));
        chk("R4 rx_data", 32'({rx_data_flags, rx_data}), 32'(m_rdata));
        if (txq.size() > 0) chk("R11 tx_head", 32'(tx_head), 32'(txq[0]));
        chk("R5 irq_id", 32'(irq_id), 32'(f_id()));
        chk("R10 irq", 32'(irq), 32'(f_id() != 4'h1));
        chk("R9 rxrdy_n", 32'(rxrdy_n),
            32'(m1 ? !(rxq.size() >= f_trig() || m_tout) : rxq.size() == 0));
        chk("R9 txrdy_n", 32'(txrdy_n),
            32'(m1 ? txq.size() == f_cap(m_en) : txq.size() != 0));
    endtask

    // One clock: inputs already driven; model follows the same edge.
    task automatic cyc();
        bit old_en, rfl, tfl, drop;
        int cap, rsz, tsz;
        old_en = m_en; cap = f_cap(old_en);
        rsz = rxq.size(); tsz = txq.size();
        rfl = 0; tfl = 0;
        @(negedge clk);
        if (ctl_wr) begin
            if (ctl_wdata[0] != m_en) begin rfl = 1; tfl = 1; end
            if (ctl_wdata[0]) begin
                if (ctl_wdata[1]) rfl = 1;
                if (ctl_wdata[2]) tfl = 1;
                m_mode = ctl_wdata[3];
                m_sel  = ctl_wdata[7:6];
            end
            m_en = ctl_wdata[0];
        end
        if (rx_push || rx_read || rfl || !old_en || rsz == 0) begin
            m_tcnt = 0; m_tout = 0;
        end else if (baud_tick && !m_tout) begin
            if (m_tcnt == int'(frame_bits) * 64 - 1) m_tout = 1;
            else m_tcnt++;
        end
        if (rx_read && rsz > 0) m_rdata = rxq[0];
        drop = rx_push && !rfl && rsz >= cap;
        if (rfl) begin
            rxq.delete(); m_ovr = 0;
        end else begin
            if (rx_read && rsz > 0) void'(rxq.pop_front());
            if (rx_push && rsz < cap) rxq.push_back({rx_flags, rx_byte});
            if (drop) m_ovr = 1;
            else if (rx_read) m_ovr = 0;
        end
        if (tfl) txq.delete();
        else begin
            if (tx_pull && tsz > 0) void'(txq.pop_front());
            if (tx_write && tsz < cap) txq.push_back(tx_byte);
        end
        ctl_wr = 0; rx_push = 0; rx_read = 0; tx_write = 0; tx_pull = 0;
        compare_all();
    endtask

    task automatic push_rx(input logic [7:0] b, input logic [2:0] f);
        rx_push = 1; rx_byte = b; rx_flags = f; cyc();
    endtask
    task automatic read_rx();
        rx_read = 1; cyc();
    endtask
    task automatic wr_ctl(input logic [7:0] v);
        ctl_wr = 1; ctl_wdata = v; cyc();
    endtask
    task automatic wr_tx(input logic [7:0] b);
        tx_write = 1; tx_byte = b; cyc();
    endtask

    initial begin
        logic [7:0] keep;
        int tr;
        int unsigned seed_v;
        seed_v = $urandom(32'd20240611);
        m_rdata = '0; m_sel = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        compare_all();                               // reset state
        chk("R10 reset id", 32'(irq_id), 32'h1);

        // R1: single-slot mode drops the second push.
        push_rx(8'h11, 3'b000);
        push_rx(8'h22, 3'b000);
        chk("R1 one slot", 32'(rx_count), 32'd1);
        chk("R6 overrun id", 32'(irq_id), 32'h6);
        read_rx();
        chk("R4 read value", 32'(rx_data), 32'h11);
        chk("R3 overrun cleared", 32'(overrun), 32'd0);

        // R1: enabling flushes; R5 trigger 14.
        push_rx(8'h33, 3'b000);
        wr_ctl(8'hC1);
        chk("R1 enable flush", 32'(rx_count), 32'd0);
        for (int i = 0; i < 13; i++) push_rx(8'(i), 3'b000);
        chk("R5 below 14", 32'(irq_id), 32'h1);
        push_rx(8'h40, 3'b000);
        chk("R5 at 14", 32'(irq_id), 32'h4);
        read_rx();
        chk("R5 drop below", 32'(irq_id), 32'h1);
        wr_ctl(8'h00);
        chk("R1 disable flush", 32'(rx_count), 32'd0);
        wr_ctl(8'hC1);

        // R2: separate flushes.
        for (int i = 0; i < 3; i++) push_rx(8'h50 + 8'(i), 3'b000);
        wr_tx(8'hA1); wr_tx(8'hA2);
        wr_ctl(8'hC3);
        chk("R2 rx flushed", 32'(rx_count), 32'd0);
        chk("R2 tx kept", 32'(tx_count), 32'd2);
        wr_ctl(8'hC5);
        chk("R2 tx flushed", 32'(tx_count), 32'd0);

        // R5: every trigger level.
        for (int s = 0; s < 4; s++) begin
            wr_ctl(8'((s << 6) | 3));
            tr = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
            for (int i = 0; i < tr - 1; i++) push_rx(8'(i), 3'b000);
            if (tr > 1) chk("R5 level-1", 32'(irq_id), 32'h1);
            push_rx(8'hEE, 3'b000);
            chk("R5 level", 32'(irq_id), 32'h4);
        end

        // R7: timeout after 64*7 ticks, cleared by read.
        wr_ctl(8'h43);
        push_rx(8'h61, 3'b000);
        baud_tick = 1;
        repeat (447) cyc();
        chk("R7 not yet", 32'(irq_id), 32'h1);
        cyc();
        chk("R7 expired", 32'(irq_id), 32'hC);
        chk("R9 mode0 rxrdy", 32'(rxrdy_n), 32'd0);
        baud_tick = 0;
        push_rx(8'h62, 3'b000);
        chk("R7 push clears", 32'(irq_id), 32'h1);
        baud_tick = 1;
        repeat (448) cyc();
        chk("R7 expired again", 32'(irq_id), 32'hC);
        baud_tick = 0;
        read_rx();
        chk("R7 read clears", 32'(irq_id), 32'h1);
        chk("R7 one left", 32'(rx_count), 32'd1);

        // R9: mode 1 request levels.
        wr_ctl(8'h4B);
        push_rx(8'h70, 3'b000);
        chk("R9 m1 below", 32'(rxrdy_n), 32'd1);
        for (int i = 0; i < 3; i++) push_rx(8'h71 + 8'(i), 3'b000);
        chk("R9 m1 at trig", 32'(rxrdy_n), 32'd0);
        chk("R9 m1 tx space", 32'(txrdy_n), 32'd0);
        for (int i = 0; i < 16; i++) wr_tx(8'hB0 + 8'(i));
        chk("R9 m1 tx full", 32'(txrdy_n), 32'd1);
        wr_tx(8'hFF);
        chk("R11 full write", 32'(tx_count), 32'd16);
        wr_ctl(8'h41);
        chk("R9 m0 tx busy", 32'(txrdy_n), 32'd1);
        tx_pull = 1; cyc();
        chk("R11 order", 32'(tx_head), 32'hB1);
        for (int i = 0; i < 16; i++) begin tx_pull = 1; cyc(); end
        chk("R9 m0 tx empty", 32'(txrdy_n), 32'd0);

        // R6: flagged head outranks data-available.
        wr_ctl(8'h03);
        push_rx(8'h55, 3'b010);
        chk("R6 flagged", 32'(irq_id), 32'h6);
        push_rx(8'h56, 3'b000);
        chk("R6 over rda", 32'(irq_id), 32'h6);
        read_rx();
        chk("R6 then rda", 32'(irq_id), 32'h4);
        chk("R4 flags out", 32'(rx_data_flags), 32'h2);

        // R2/R3: same-cycle collisions.
        rx_push = 1; rx_byte = 8'h99; rx_flags = 0; ctl_wr = 1; ctl_wdata = 8'h03; cyc();
        chk("R2 flush beats push", 32'(rx_count), 32'd0);
        for (int i = 0; i < 16; i++) push_rx(8'h80 + 8'(i), 3'b000);
        rx_push = 1; rx_byte = 8'hAA; rx_read = 1; cyc();
        chk("R3 full push+read", 32'(rx_count), 32'd15);
        chk("R3 overrun set", 32'(overrun), 32'd1);
        chk("R4 read on full", 32'(rx_data), 32'h80);

        // R4: read from empty.
        wr_ctl(8'h03);
        keep = rx_data;
        read_rx();
        chk("R4 empty read", 32'(rx_data), 32'(keep));
        chk("R4 empty count", 32'(rx_count), 32'd0);

        // R10: masked interrupts.
        rx_ie = 0;
        push_rx(8'h01, 3'b100);
        chk("R10 masked", 32'(irq), 32'd0);
        chk("R10 masked id", 32'(irq_id), 32'h1);
        rx_ie = 1;
        wr_ctl(8'h43);

        // Random traffic.
        for (int i = 0; i < 3000; i++) begin
            rx_push   = ($urandom % 100) < 40;
            rx_byte   = 8'($urandom);
            rx_flags  = (($urandom % 16) == 0) ? 3'(($urandom % 7) + 1) : 3'b000;
            rx_read   = ($urandom % 100) < 35;
            tx_write  = ($urandom % 100) < 30;
            tx_byte   = 8'($urandom);
            tx_pull   = ($urandom % 100) < 30;
            baud_tick = ($urandom % 4) == 0;
            if (($urandom % 150) == 0) begin
                ctl_wr = 1;
                ctl_wdata = 8'($urandom);
                ctl_wdata[0] = (($urandom % 8) != 0);
            end
            cyc();
        end
        baud_tick = 0;
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule